// File: doc/BRIEF.md
# Cycle-stealing memory access arbiter

This block decides which of two requesters, a processor and a DMA engine, owns each access on a single shared main-memory port. The DMA engine does not hold the port for a whole block transfer. It takes one memory access per grant and gives the port back at the end of it. An access in progress always runs to its end. A request that arrives during an access waits for the next free slot.

Each access lasts `ACCESS_CYCLES` clock cycles. The winner's grant rises on the clock edge after arbitration. It stays high for exactly that many cycles, and `busy` is high for the same span. `last` marks the final cycle of the access. In that cycle the block arbitrates again, so a waiting requester takes over with no idle cycle in between. When both sides request at a free slot, the DMA side wins. Requests are levels: a requester holds its request high until it sees its grant, and the grant clears the request.

Top module: `cs_mem_arbiter`

## Requirements
- R1: While `rst_n` is low, `cpu_gnt`, `dma_gnt`, `busy` and `last` are all low after the next rising clock edge.
- R2: When the port is idle and `dma_req` is high at a rising edge, `dma_gnt` is high after that edge.
- R3: When the port is idle, `cpu_req` is high and `dma_req` is low at a rising edge, `cpu_gnt` is high after that edge.
- R4: Once a grant rises, it stays high for exactly `ACCESS_CYCLES` consecutive cycles, whatever the requests do. `last` is high only in the final one of them, so an access is never cut short.
- R5: A `dma_req` raised during a processor access is not granted before that access ends. `dma_gnt` rises in the cycle right after the processor access's `last` cycle.
- R6: When both requests are high at a free slot (idle, or the `last` cycle of an access), the DMA side is granted and the processor is not.
- R7: At most one grant is high in any cycle, and `busy` is high exactly when one of them is.
- R8: A processor request that loses a tie stays pending and is granted in the cycle after the DMA access's `last` cycle, provided `dma_req` is low at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor wants a memory access (level) |
| dma_req | input | 1 | DMA engine wants a memory access (level) |
| cpu_gnt | output | 1 | Processor owns the current memory access |
| dma_gnt | output | 1 | DMA engine owns the current memory access |
| busy | output | 1 | A memory access is in progress |
| last | output | 1 | Final cycle of the current access |

## Verification
The block is tried with a single request on an idle port from each side. This shows that the grant goes out at once when nobody holds the port. A DMA request raised in the middle of a processor access shows that an access is never cut short and that the DMA side is served straight after. Simultaneous requests, with the processor request held on, separate the tie rule from plain first-come order and show that the losing request survives. A long random stretch, with a mid-run reset, is compared every cycle against a counter-based model. This covers back-to-back accesses and requests that drop before they are granted.

// File: rtl/cs_mem_arbiter.sv
module cs_mem_arbiter #(
  parameter int unsigned ACCESS_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic dma_req,
  output logic cpu_gnt,
  output logic dma_gnt,
  output logic busy,
  output logic last
);
  localparam int unsigned CW = (ACCESS_CYCLES > 1) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CW-1:0] END_CNT = CW'(ACCESS_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          cpu_q, dma_q;
  logic          slot_free;

  assign busy      = cpu_q | dma_q;
  assign last      = busy && (cnt == END_CNT);
  assign slot_free = !busy || last;
  assign cpu_gnt   = cpu_q;
  assign dma_gnt   = dma_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_q <= 1'b0;
      dma_q <= 1'b0;
      cnt   <= '0;
    end else if (slot_free) begin
      dma_q <= dma_req;
      cpu_q <= cpu_req && !dma_req;
      cnt   <= '0;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

module cs_mem_arbiter_chk #(
  parameter int unsigned ACCESS_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cpu_req,
  input logic dma_req,
  input logic cpu_gnt,
  input logic dma_gnt,
  input logic busy,
  input logic last
);
  int unsigned run;
  logic        free_now;
  assign free_now = !busy || last;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || last) run <= 0;
    else                         run <= run + 1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !busy && !last && !cpu_gnt && !dma_gnt);
  a_r7_one_grant:    assert property (@(posedge clk) disable iff (!rst_n) !(cpu_gnt && dma_gnt));
  a_r7_busy_match:   assert property (@(posedge clk) disable iff (!rst_n) busy == (cpu_gnt || dma_gnt));
  a_r4_no_cut:       assert property (@(posedge clk) disable iff (!rst_n) busy && !last |=> $stable(cpu_gnt) && $stable(dma_gnt) && busy);
  a_r4_full_length:  assert property (@(posedge clk) disable iff (!rst_n) last |-> run == ACCESS_CYCLES - 1);
  a_r4_not_long:     assert property (@(posedge clk) disable iff (!rst_n) busy |-> run < ACCESS_CYCLES);
  a_r6_dma_wins:     assert property (@(posedge clk) disable iff (!rst_n) free_now && dma_req |=> dma_gnt && !cpu_gnt);
  a_r3_cpu_alone:    assert property (@(posedge clk) disable iff (!rst_n) free_now && cpu_req && !dma_req |=> cpu_gnt);
  a_r5_dma_waits:    assert property (@(posedge clk) disable iff (!rst_n) cpu_gnt && !last |=> !dma_gnt);
endmodule

bind cs_mem_arbiter cs_mem_arbiter_chk #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_chk (.*);

// File: tb/test_cs_mem_arbiter.sv
`timescale 1ns/1ps
module test_cs_mem_arbiter;
  localparam int unsigned N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, dma_req = 1'b0;
  logic cpu_gnt, dma_gnt, busy, last;

  int errors = 0, checks = 0;
  string phase = "R1";
  bit finished = 1'b0;

  int owner = 0;
  int rem = 0;

  always #10 clk = ~clk;

  cs_mem_arbiter #(.ACCESS_CYCLES(N)) i_cs_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .busy(busy), .last(last));

  always @(posedge clk) begin
    if (!rst_n) begin
      owner = 0;
      rem = 0;
    end else if (owner == 0 || rem == 1) begin
      owner = dma_req ? 2 : (cpu_req ? 1 : 0);
      rem = N;
    end else begin
      rem = rem - 1;
    end
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t {cpu_gnt,dma_gnt,busy,last} actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [3:0] exp;
      exp = {owner == 1, owner == 2, owner != 0, owner != 0 && rem == 1};
      check(phase, {cpu_gnt, dma_gnt, busy, last}, exp);
      checks++;
      if (cpu_gnt && dma_gnt) begin
        errors++;
        $display("FAIL R7 t=%0t both grants actual=11 expected at most one", $time);
      end
    end
  end

  task automatic cyc(input logic c, input logic d, input int n = 1);
    cpu_req = c;
    dma_req = d;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 1, 3);
    rst_n = 1'b1;
    phase = "R2";  cyc(0, 1); cyc(0, 0, 5);
    phase = "R3";  cyc(1, 0); cyc(0, 0, 5);
    phase = "R5";  cyc(1, 0); cyc(0, 1, 3); cyc(0, 0, 5);
    phase = "R6";  cyc(1, 1);
    phase = "R8";  cyc(1, 0, 4); cyc(0, 0, 5);
    phase = "R4";  cyc(0, 1, 9); cyc(1, 0, 7); cyc(0, 0, 4);
    phase = "R7";
    for (int i = 0; i < 600; i++) begin
      if (i == 300) begin
        phase = "R1"; rst_n = 1'b0; cyc(1, 1, 2); rst_n = 1'b1; phase = "R7";
      end
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    cyc(0, 0, 5);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule